// File: doc/BRIEF.md
# Exception and Interrupt Control Register Unit

This block is the system-control register file of a simple 32-bit processor. It keeps the processor status word (interrupt mask, exception-level flag, interrupt enable), the cause word (pending interrupt levels, exception code, branch-delay flag), the saved return address, a free-running cycle counter and a compare register. The pipeline reads and writes these registers by register number through a single move port, signals exception entry with a strobe that carries the code, the return address and the branch-delay flag, and signals exception return with a second strobe.

The unit samples six hardware interrupt lines every cycle and holds two software-settable interrupt levels. It reduces the pending levels, the mask, the enable and the exception-level flag to one interrupt request toward the pipeline. It also presents the fixed handler entry address and the saved return address. The move port is a plain single-cycle strobe: every request is accepted in the cycle it is presented, no back-pressure exists, and reads are combinational from the selected register number.

Top module: `exc_ctl_regs`

## Requirements
- R1: After reset, Status (register 12) reads 0x00000010, Cause (register 13) reads 0x00000000 while the hardware lines are low, and `irq_req` is 0.
- R2: A move-to Status stores bits 15:8 (mask, one bit per level), bit 1 (exception level) and bit 0 (interrupt enable); bit 4 (user mode) always reads 1 and every other bit reads 0.
- R3: Cause bits 9:8 are software pending levels set or cleared by a move-to Cause; Cause bits 15:10 show `hw_irq[5:0]` sampled at the previous clock edge and ignore writes; bits 31 and 6:2 ignore writes.
- R4: `irq_req` is 1 exactly when interrupt enable is 1, exception level is 0 and some pending bit of Cause[15:8] has its mask bit in Status[15:8] set.
- R5: On `exc_take`, after the edge the exception-level bit is 1, Cause[6:2] holds `exc_code`, Cause[31] holds `exc_bd`, register 14 holds `exc_pc`, and the mask and enable bits are unchanged; codes 0, 4 to 10 and 12 are all stored as given.
- R6: On `exc_ret` without `exc_take`, the exception-level bit becomes 0, mask and enable are unchanged, and `resume_pc` always shows register 14.
- R7: Priority: `exc_take` beats `exc_ret` and beats a same-cycle move-to of Status, Cause or register 14 (the write is dropped); `exc_ret` beats a same-cycle move-to of Status.
- R8: Count (register 9) increases by one each cycle; a move-to loads it and it reads the written value in the next cycle; Compare (register 11) holds the last value written.
- R9: Move-from any register number other than 9, 11, 12, 13 and 14 returns 0.
- R10: `vector_pc` is always 0x80000180.
- R11: Pending levels stay recorded while interrupts are disabled, so enabling interrupts later raises `irq_req` with no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_wr | input | 1 | Move-to strobe |
| xfer_num | input | 5 | Register number for move-to and move-from |
| xfer_wdata | input | 32 | Move-to data |
| xfer_rdata | output | 32 | Move-from data for `xfer_num` |
| hw_irq | input | 6 | Hardware interrupt lines, levels 2 to 7 |
| exc_take | input | 1 | Exception entry strobe |
| exc_code | input | 5 | Exception code for entry |
| exc_pc | input | 32 | Return address saved on entry |
| exc_bd | input | 1 | Branch-delay flag saved on entry |
| exc_ret | input | 1 | Exception return strobe |
| irq_req | output | 1 | Take-interrupt request |
| vector_pc | output | 32 | Handler entry address |
| resume_pc | output | 32 | Saved return address |

## Verification
The hardest situation to reach is the full interaction of enable, exception level, eight masks and eight pending sources, because the hardware sources arrive one edge late and the software ones only through writes. The bench sweeps every enable and exception-level combination against walking-one, empty and full masks and all 256 pending patterns, writing Status and Cause back to back and checking the request once both have settled. Same-cycle collisions of entry, return and moves are forced by raising the strobes in one cycle.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
  localparam int XLEN   = 32;
  localparam int RNUM_W = 5;
  localparam int CODE_W = 5;

  localparam logic [RNUM_W-1:0] RN_COUNT   = 5'd9;
  localparam logic [RNUM_W-1:0] RN_COMPARE = 5'd11;
  localparam logic [RNUM_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [RNUM_W-1:0] RN_RETPC   = 5'd14;

  localparam int LVL_LO  = 8;   // mask and pending fields start here
  localparam int CODE_LO = 2;
  localparam int BD_BIT  = 31;
  localparam int UM_BIT  = 4;
  localparam int EXL_BIT = 1;
  localparam int IE_BIT  = 0;

  localparam logic [XLEN-1:0] TRAP_VECTOR = 32'h8000_0180;
endpackage

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int LEVELS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LEVELS-1:0] wr_mask,
  input  logic              wr_exl,
  input  logic              wr_ie,
  input  logic              take,
  input  logic              ret,
  output logic [LEVELS-1:0] mask,
  output logic              exl,
  output logic              ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      exl  <= 1'b0;
      ie   <= 1'b0;
    end else if (take) begin
      exl <= 1'b1;
    end else if (ret) begin
      exl <= 1'b0;
    end else if (wr) begin
      mask <= wr_mask;
      exl  <= wr_exl;
      ie   <= wr_ie;
    end
  end

  p_entry_sets_exl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> exl);
  p_entry_keeps_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($stable(mask) && $stable(ie)));
  p_return_clears_exl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> !exl);
  p_return_keeps_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> ($stable(mask) && $stable(ie)));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg #(
  parameter int HW_LINES = 6,
  parameter int SW_LINES = 2,
  parameter int CODE_W   = 5,
  localparam int LEVELS  = HW_LINES + SW_LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SW_LINES-1:0] wr_sw,
  input  logic [HW_LINES-1:0] hw_irq,
  input  logic                take,
  input  logic [CODE_W-1:0]   take_code,
  input  logic                take_bd,
  output logic [LEVELS-1:0]   pend,
  output logic [CODE_W-1:0]   code,
  output logic                bd
);
  logic [SW_LINES-1:0] sw_q;
  logic [HW_LINES-1:0] hw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      hw_q <= '0;
      code <= '0;
      bd   <= 1'b0;
    end else begin
      hw_q <= hw_irq;
      if (wr) sw_q <= wr_sw;
      if (take) begin
        code <= take_code;
        bd   <= take_bd;
      end
    end
  end

  assign pend = {hw_q, sw_q};

  p_code_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(code) && $stable(bd)));
  p_code_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (code == $past(take_code)));
  p_sw_pend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pend[SW_LINES-1:0]));
endmodule

// File: rtl/exc_timer_regs.sv
module exc_timer_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_wr,
  input  logic            cmp_wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] count,
  output logic [XLEN-1:0] compare
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      compare <= '0;
    end else begin
      count <= cnt_wr ? wdata : count + 1'b1;
      if (cmp_wr) compare <= wdata;
    end
  end

  p_count_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count) + 1'b1));
  p_compare_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_wr |=> $stable(compare));
endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int LEVELS = 8
) (
  input  logic [LEVELS-1:0] pend,
  input  logic [LEVELS-1:0] mask,
  input  logic              ie,
  input  logic              exl,
  output logic              irq
);
  logic [LEVELS-1:0] hit;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign hit[g] = pend[g] & mask[g];
  end

  assign irq = ie & ~exl & (|hit);
endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs
  import exc_ctl_pkg::*;
#(
  parameter int HW_LINES = 6,
  parameter int SW_LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_wr,
  input  logic [RNUM_W-1:0] xfer_num,
  input  logic [XLEN-1:0]   xfer_wdata,
  output logic [XLEN-1:0]   xfer_rdata,
  input  logic [HW_LINES-1:0] hw_irq,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              exc_bd,
  input  logic              exc_ret,
  output logic              irq_req,
  output logic [XLEN-1:0]   vector_pc,
  output logic [XLEN-1:0]   resume_pc
);
  localparam int LEVELS = HW_LINES + SW_LINES;

  logic              wr_status, wr_cause, wr_retpc, wr_count, wr_compare;
  logic [LEVELS-1:0] st_mask, pend;
  logic              st_exl, st_ie, ca_bd;
  logic [CODE_W-1:0] ca_code;
  logic [XLEN-1:0]   count, compare, ret_pc;

  assign wr_status  = xfer_wr && (xfer_num == RN_STATUS);
  assign wr_cause   = xfer_wr && (xfer_num == RN_CAUSE) && !exc_take;
  assign wr_retpc   = xfer_wr && (xfer_num == RN_RETPC);
  assign wr_count   = xfer_wr && (xfer_num == RN_COUNT);
  assign wr_compare = xfer_wr && (xfer_num == RN_COMPARE);

  exc_status_reg #(.LEVELS(LEVELS)) u_status (
    .clk(clk), .rst_n(rst_n), .wr(wr_status),
    .wr_mask(xfer_wdata[LVL_LO +: LEVELS]),
    .wr_exl(xfer_wdata[EXL_BIT]), .wr_ie(xfer_wdata[IE_BIT]),
    .take(exc_take), .ret(exc_ret),
    .mask(st_mask), .exl(st_exl), .ie(st_ie)
  );

  exc_cause_reg #(.HW_LINES(HW_LINES), .SW_LINES(SW_LINES), .CODE_W(CODE_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .wr(wr_cause),
    .wr_sw(xfer_wdata[LVL_LO +: SW_LINES]), .hw_irq(hw_irq),
    .take(exc_take), .take_code(exc_code), .take_bd(exc_bd),
    .pend(pend), .code(ca_code), .bd(ca_bd)
  );

  exc_timer_regs #(.XLEN(XLEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .cnt_wr(wr_count), .cmp_wr(wr_compare),
    .wdata(xfer_wdata), .count(count), .compare(compare)
  );

  exc_irq_gate #(.LEVELS(LEVELS)) u_gate (
    .pend(pend), .mask(st_mask), .ie(st_ie), .exl(st_exl), .irq(irq_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ret_pc <= '0;
    else if (exc_take)   ret_pc <= exc_pc;
    else if (wr_retpc)   ret_pc <= xfer_wdata;
  end

  always_comb begin
    xfer_rdata = '0;
    case (xfer_num)
      RN_COUNT:   xfer_rdata = count;
      RN_COMPARE: xfer_rdata = compare;
      RN_STATUS: begin
        xfer_rdata[LVL_LO +: LEVELS] = st_mask;
        xfer_rdata[UM_BIT]           = 1'b1;
        xfer_rdata[EXL_BIT]          = st_exl;
        xfer_rdata[IE_BIT]           = st_ie;
      end
      RN_CAUSE: begin
        xfer_rdata[BD_BIT]            = ca_bd;
        xfer_rdata[LVL_LO +: LEVELS]  = pend;
        xfer_rdata[CODE_LO +: CODE_W] = ca_code;
      end
      RN_RETPC:   xfer_rdata = ret_pc;
      default:    xfer_rdata = '0;
    endcase
  end

  assign vector_pc = TRAP_VECTOR;
  assign resume_pc = ret_pc;

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (st_ie && !st_exl));
  p_no_irq_after_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !irq_req);
  p_retpc_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (resume_pc == $past(exc_pc)));
  p_entry_beats_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && wr_status) |=> st_exl);
  p_vector_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vector_pc == 32'h8000_0180);
endmodule

// File: tb/tb_exc_ctl_regs.sv
module tb_exc_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_wr = 1'b0;
  logic [4:0]  xfer_num = '0;
  logic [31:0] xfer_wdata = '0;
  logic [31:0] xfer_rdata;
  logic [5:0]  hw_irq = '0;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_bd = 1'b0;
  logic        exc_ret = 1'b0;
  logic        irq_req;
  logic [31:0] vector_pc, resume_pc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .xfer_wr(xfer_wr), .xfer_num(xfer_num),
    .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata), .hw_irq(hw_irq),
    .exc_take(exc_take), .exc_code(exc_code), .exc_pc(exc_pc), .exc_bd(exc_bd),
    .exc_ret(exc_ret), .irq_req(irq_req), .vector_pc(vector_pc), .resume_pc(resume_pc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic xwr(input logic [4:0] n, input logic [31:0] d);
    xfer_wr = 1'b1; xfer_num = n; xfer_wdata = d;
    @(negedge clk);
    xfer_wr = 1'b0;
  endtask

  task automatic xrd(input logic [4:0] n, output logic [31:0] d);
    xfer_num = n;
    #1;
    d = xfer_rdata;
  endtask

  task automatic enter(input logic [4:0] c, input logic [31:0] pc, input logic bd);
    exc_take = 1'b1; exc_code = c; exc_pc = pc; exc_bd = bd;
    @(negedge clk);
    exc_take = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  pend8;
    logic        exp_irq;
    logic [7:0]  mvals [10];
    int          codes [9];
    mvals[0] = 8'h00; mvals[9] = 8'hFF;
    for (int k = 0; k < 8; k++) mvals[k+1] = 8'(1 << k);
    codes = '{0, 4, 5, 6, 7, 8, 9, 10, 12};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 vector
    xrd(5'd12, rd); chk("R1 status reset", rd, 32'h10);
    xrd(5'd13, rd); chk("R1 cause reset", rd, 32'h0);
    chk("R1 irq reset", {31'b0, irq_req}, 32'h0);
    chk("R10 vector", vector_pc, 32'h8000_0180);

    // R2 status field masking
    xwr(5'd12, 32'hFFFF_FFFF); xrd(5'd12, rd); chk("R2 status all ones", rd, 32'h0000_FF13);
    xwr(5'd12, 32'h0000_0000); xrd(5'd12, rd); chk("R2 status zero keeps user bit", rd, 32'h10);
    xwr(5'd12, 32'hA5A5_5AEE); xrd(5'd12, rd); chk("R2 status pattern", rd, 32'h0000_5A12);

    // R3 cause writable and read-only parts
    xwr(5'd12, 32'h0);
    hw_irq = 6'h2A;
    xwr(5'd13, 32'hFFFF_FFFF); xrd(5'd13, rd); chk("R3 cause sw and hw bits", rd, 32'h0000_AB00);
    hw_irq = 6'h00;
    xwr(5'd13, 32'h0000_0100); xrd(5'd13, rd); chk("R3 cause hw follows line", rd, 32'h0000_0100);
    xwr(5'd13, 32'h0); xrd(5'd13, rd); chk("R3 cause cleared", rd, 32'h0);

    // R4 sweep: enable x level x mask x every pending pattern
    for (int ie = 0; ie < 2; ie++)
      for (int ex = 0; ex < 2; ex++)
        for (int mi = 0; mi < 10; mi++)
          for (int p = 0; p < 256; p++) begin
            pend8  = 8'(p);
            hw_irq = pend8[7:2];
            xwr(5'd12, {16'h0, mvals[mi], 6'h0, 1'(ex), 1'(ie)});
            xwr(5'd13, {22'h0, pend8[1:0], 8'h0});
            exp_irq = ie[0] & ~ex[0] & (|(pend8 & mvals[mi]));
            chk("R4 irq gate sweep", {31'b0, irq_req}, {31'b0, exp_irq});
          end
    hw_irq = 6'h0;
    xwr(5'd13, 32'h0);

    // R11 pending survives while disabled
    xwr(5'd12, 32'h0000_0200);
    xwr(5'd13, 32'h0000_0200);
    chk("R11 no irq while disabled", {31'b0, irq_req}, 32'h0);
    xwr(5'd12, 32'h0000_0201);
    chk("R11 irq once enabled", {31'b0, irq_req}, 32'h1);

    // R5 entry, R6 return
    xwr(5'd12, 32'h0000_FF01);
    xwr(5'd13, 32'h0000_0100);
    enter(5'd0, 32'h0040_0020, 1'b1);
    xrd(5'd12, rd); chk("R5 entry sets level", rd, 32'h0000_FF13);
    xrd(5'd13, rd); chk("R5 entry cause", rd, 32'h8000_0100);
    xrd(5'd14, rd); chk("R5 entry return address", rd, 32'h0040_0020);
    chk("R4 irq blocked during exception", {31'b0, irq_req}, 32'h0);
    exc_ret = 1'b1; @(negedge clk); exc_ret = 1'b0;
    xrd(5'd12, rd); chk("R6 return clears level", rd, 32'h0000_FF11);
    chk("R6 resume address", resume_pc, 32'h0040_0020);
    chk("R6 irq again after return", {31'b0, irq_req}, 32'h1);
    xwr(5'd13, 32'h0);
    foreach (codes[i]) begin
      enter(5'(codes[i]), 32'h1000 + 32'(i * 4), 1'b0);
      xrd(5'd13, rd); chk("R5 code stored", rd, 32'(codes[i]) << 2);
      xrd(5'd14, rd); chk("R5 address stored", rd, 32'h1000 + 32'(i * 4));
      exc_ret = 1'b1; @(negedge clk); exc_ret = 1'b0;
    end

    // R7 priorities
    xwr(5'd12, 32'h0000_FF01);
    exc_take = 1'b1; exc_code = 5'd8; exc_pc = 32'h7000; exc_bd = 1'b0;
    xfer_wr = 1'b1; xfer_num = 5'd12; xfer_wdata = 32'h0;
    @(negedge clk); exc_take = 1'b0; xfer_wr = 1'b0;
    xrd(5'd12, rd); chk("R7 entry beats status move", rd, 32'h0000_FF13);
    exc_ret = 1'b1; xfer_wr = 1'b1; xfer_num = 5'd12; xfer_wdata = 32'h0;
    @(negedge clk); exc_ret = 1'b0; xfer_wr = 1'b0;
    xrd(5'd12, rd); chk("R7 return beats status move", rd, 32'h0000_FF11);
    exc_take = 1'b1; exc_code = 5'd12; exc_pc = 32'h7100;
    xfer_wr = 1'b1; xfer_num = 5'd14; xfer_wdata = 32'h5555;
    @(negedge clk); exc_take = 1'b0; xfer_wr = 1'b0;
    xrd(5'd14, rd); chk("R7 entry beats address move", rd, 32'h7100);
    exc_ret = 1'b1; @(negedge clk); exc_ret = 1'b0;
    exc_take = 1'b1; exc_code = 5'd9; exc_pc = 32'h7200;
    xfer_wr = 1'b1; xfer_num = 5'd13; xfer_wdata = 32'h0000_0300;
    @(negedge clk); exc_take = 1'b0; xfer_wr = 1'b0;
    xrd(5'd13, rd); chk("R7 entry beats cause move", rd, 32'h0000_0024);
    exc_take = 1'b1; exc_ret = 1'b1; exc_code = 5'd10; exc_pc = 32'h7300;
    @(negedge clk); exc_take = 1'b0; exc_ret = 1'b0;
    xrd(5'd12, rd); chk("R7 entry beats return", rd, 32'h0000_FF13);

    // R8 count and compare
    xwr(5'd9, 32'd100);
    xrd(5'd9, rd); chk("R8 count loaded", rd, 32'd100);
    repeat (5) @(negedge clk);
    xrd(5'd9, rd); chk("R8 count advances", rd, 32'd105);
    xwr(5'd9, 32'hFFFF_FFFF);
    @(negedge clk);
    xrd(5'd9, rd); chk("R8 count wraps", rd, 32'h0);
    xwr(5'd11, 32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    xrd(5'd11, rd); chk("R8 compare holds", rd, 32'hDEAD_BEEF);

    // R9 unimplemented numbers
    xwr(5'd8, 32'h1234_5678);
    foreach (codes[i]) begin
      logic [4:0] n;
      n = (i == 0) ? 5'd0 : (i == 1) ? 5'd8 : (i == 2) ? 5'd10 : (i == 3) ? 5'd15 : 5'(16 + i);
      xrd(n, rd); chk("R9 unimplemented reads zero", rd, 32'h0);
    end
    chk("R10 vector unchanged", vector_pc, 32'h8000_0180);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule